// File: doc/BRIEF.md
# Pin Bank with Level and Edge Interrupt Detection

A 32-pin general-purpose I/O bank on a 32-bit register bus. Each pin has a direction bit, an output value and a synchronised input value. Four detection enables per pin select low level, high level, rising edge and falling edge. These enables are independent and can be combined freely. Any enabled condition that is met sets the pin's bit in a shared interrupt status register.

Software clears status bits by writing ones to them. A bit set by an edge stays cleared until the next edge. A bit whose level condition is still true sets again on the next cycle, so a level source cannot be lost. An interrupt enable mask and a wake enable mask each reduce the status to one output line. Both masks, and the output value, also have set and clear alias addresses that act only on the bits written as one.

Writes are single-cycle strobes. Reads are combinational from the address. The register offsets are fixed, because driver software decodes them.

Top module: `pin_bank_irq`

## Requirements
- R1: After reset every direction bit is 1 (input), and the output value, all detect enables, interrupt enables, wake enables and status are 0; `irq_o` and `wake_o` are low.
- R2: The direction register at 0x34 reads back as written and drives `pin_dir_in`. A 1 means input and a 0 means output.
- R3: The output register at 0x3C drives `pin_o`. A write to 0x94 sets the bits written as 1, and a write to 0x90 clears them. Bits written as 0 keep their value.
- R4: The data-in register at 0x38 returns each pin through a two-flop synchroniser. A pin change driven before a clock edge becomes readable after the second edge, and not after the first.
- R5: With the low-level enable (0x40) set, a pin's status bit sets while its synchronised input is 0.
- R6: With the high-level enable (0x44) set, a pin's status bit sets while its synchronised input is 1.
- R7: With the rising enable (0x48) set, a synchronised 0-to-1 change sets the status bit once. The bit does not set again while the pin stays high.
- R8: With the falling enable (0x4C) set, a synchronised 1-to-0 change sets the status bit.
- R9: The four enables of one pin may be combined. The status bit sets when any of the enabled conditions occurs.
- R10: Writing 1 to a bit of the status register at 0x18 clears it, and bits written as 0 are unchanged. A bit whose enabled level is still present reads 1 again right after the clear.
- R11: When a detection for a bit falls in the same cycle as a write that clears that bit, the bit stays set.
- R12: `irq_o` is the OR over pins of status AND interrupt enable. The interrupt enable is written directly at 0x1C, set through 0x64 and cleared through 0x60.
- R13: `wake_o` is the OR over pins of status AND wake enable. The wake enable is set through 0x84, cleared through 0x80, and reads back at either address.
- R14: Address 0x00 reads the revision parameter, 0x14 reads 1 (reset done), and 0x10 and 0x30 are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_i | input | 32 | Pin input levels, asynchronous |
| pin_o | output | 32 | Pin output values |
| pin_dir_in | output | 32 | Per-pin direction, 1 = input |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
A detection and a software clear of the same status bit can fall in one cycle. The bench provokes this by first letting a rising edge set bit 1 and return low. It then drives a second rise and places the status-clear write on exactly the edge where the synchronised rise is first seen. The status must keep bit 1 and lose bit 2, which had no new event. A level condition that is still present while the clear lands is judged the same way, through the sweep that reads the status after a full clear.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    // The bus is 32 bits wide and each register holds one bit per pin.
    localparam int PINS = 32;
    localparam int AW   = 8;

    typedef logic [PINS-1:0] pvec_t;

    localparam logic [AW-1:0] OFS_REV      = 8'h00;
    localparam logic [AW-1:0] OFS_SYSCFG   = 8'h10;
    localparam logic [AW-1:0] OFS_SYSSTAT  = 8'h14;
    localparam logic [AW-1:0] OFS_STAT     = 8'h18;
    localparam logic [AW-1:0] OFS_IEN      = 8'h1C;
    localparam logic [AW-1:0] OFS_CTRL     = 8'h30;
    localparam logic [AW-1:0] OFS_DIR      = 8'h34;
    localparam logic [AW-1:0] OFS_DIN      = 8'h38;
    localparam logic [AW-1:0] OFS_DOUT     = 8'h3C;
    localparam logic [AW-1:0] OFS_DET_LO   = 8'h40;
    localparam logic [AW-1:0] OFS_DET_HI   = 8'h44;
    localparam logic [AW-1:0] OFS_DET_RISE = 8'h48;
    localparam logic [AW-1:0] OFS_DET_FALL = 8'h4C;
    localparam logic [AW-1:0] OFS_IEN_CLR  = 8'h60;
    localparam logic [AW-1:0] OFS_IEN_SET  = 8'h64;
    localparam logic [AW-1:0] OFS_WK_CLR   = 8'h80;
    localparam logic [AW-1:0] OFS_WK_SET   = 8'h84;
    localparam logic [AW-1:0] OFS_DOUT_CLR = 8'h90;
    localparam logic [AW-1:0] OFS_DOUT_SET = 8'h94;

    typedef struct packed {
        pvec_t       dir_in;
        pvec_t       dout;
        pvec_t       irq_en;
        pvec_t       wake_en;
        pvec_t       det_lo;
        pvec_t       det_hi;
        pvec_t       det_rise;
        pvec_t       det_fall;
        pvec_t       status;
        logic [31:0] sysconf;
        logic [31:0] ctrl;
    } regs_t;

    typedef struct packed {
        pvec_t meta;
        pvec_t sync;
        pvec_t prev;
    } samp_t;
endpackage

// File: rtl/gpb_sample_detect.sv
module gpb_sample_detect
    import gpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pvec_t pin_i,
    input  pvec_t det_lo,
    input  pvec_t det_hi,
    input  pvec_t det_rise,
    input  pvec_t det_fall,
    output pvec_t level_o,
    output pvec_t evt_o
);
    samp_t samp_d, samp_q;

    always_comb begin
        samp_d      = samp_q;
        samp_d.meta = pin_i;
        samp_d.sync = samp_q.meta;
        samp_d.prev = samp_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign level_o = samp_q.sync;

    // One detector per pin; any enabled condition raises the event.
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic now_v, was_v;
        assign now_v = samp_q.sync[i];
        assign was_v = samp_q.prev[i];
        assign evt_o[i] = (det_lo[i]   & ~now_v)
                        | (det_hi[i]   &  now_v)
                        | (det_rise[i] &  now_v & ~was_v)
                        | (det_fall[i] & ~now_v &  was_v);
    end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter logic [31:0] REV_ID = 32'h0000_0018
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  pvec_t         bus_wdata,
    output pvec_t         bus_rdata,
    input  pvec_t         level_i,
    input  pvec_t         evt_i,
    output regs_t         regs_o
);
    regs_t state_d, state_q;
    pvec_t clr_mask;

    always_comb begin
        clr_mask = (bus_wr && bus_addr == OFS_STAT) ? bus_wdata : '0;
        state_d  = state_q;
        // A detection in this cycle overrides a clear of the same bit.
        state_d.status = (state_q.status & ~clr_mask) | evt_i;
        if (bus_wr) begin
            case (bus_addr)
                OFS_SYSCFG:   state_d.sysconf  = bus_wdata;
                OFS_CTRL:     state_d.ctrl     = bus_wdata;
                OFS_DIR:      state_d.dir_in   = bus_wdata;
                OFS_DOUT:     state_d.dout     = bus_wdata;
                OFS_IEN:      state_d.irq_en   = bus_wdata;
                OFS_DET_LO:   state_d.det_lo   = bus_wdata;
                OFS_DET_HI:   state_d.det_hi   = bus_wdata;
                OFS_DET_RISE: state_d.det_rise = bus_wdata;
                OFS_DET_FALL: state_d.det_fall = bus_wdata;
                OFS_IEN_CLR:  state_d.irq_en   = state_q.irq_en  & ~bus_wdata;
                OFS_IEN_SET:  state_d.irq_en   = state_q.irq_en  |  bus_wdata;
                OFS_WK_CLR:   state_d.wake_en  = state_q.wake_en & ~bus_wdata;
                OFS_WK_SET:   state_d.wake_en  = state_q.wake_en |  bus_wdata;
                OFS_DOUT_CLR: state_d.dout     = state_q.dout    & ~bus_wdata;
                OFS_DOUT_SET: state_d.dout     = state_q.dout    |  bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.dir_in <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_REV:                  bus_rdata = REV_ID;
            OFS_SYSCFG:               bus_rdata = state_q.sysconf;
            OFS_SYSSTAT:              bus_rdata = 32'h1;
            OFS_STAT:                 bus_rdata = state_q.status;
            OFS_IEN, OFS_IEN_CLR,
            OFS_IEN_SET:              bus_rdata = state_q.irq_en;
            OFS_CTRL:                 bus_rdata = state_q.ctrl;
            OFS_DIR:                  bus_rdata = state_q.dir_in;
            OFS_DIN:                  bus_rdata = level_i;
            OFS_DOUT, OFS_DOUT_CLR,
            OFS_DOUT_SET:             bus_rdata = state_q.dout;
            OFS_DET_LO:               bus_rdata = state_q.det_lo;
            OFS_DET_HI:               bus_rdata = state_q.det_hi;
            OFS_DET_RISE:             bus_rdata = state_q.det_rise;
            OFS_DET_FALL:             bus_rdata = state_q.det_fall;
            OFS_WK_CLR, OFS_WK_SET:   bus_rdata = state_q.wake_en;
            default:                  bus_rdata = '0;
        endcase
    end

    assign regs_o = state_q;

    // Status bits leave only through a clearing write.
    assert_status_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_STAT)
        |=> ((state_q.status & $past(state_q.status)) == $past(state_q.status)));

    // A detected event always lands in status, even against a clear.
    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((state_q.status & $past(evt_i)) == $past(evt_i)));

    // No status bit appears without a detection behind it.
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.status & ~$past(state_q.status) & ~$past(evt_i)) == '0);

    // The set alias raises the written bits and leaves the others alone.
    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DOUT_SET)
        |=> (((state_q.dout & $past(bus_wdata)) == $past(bus_wdata))
             && ((state_q.dout & ~$past(bus_wdata)) == ($past(state_q.dout) & ~$past(bus_wdata)))));

    // The clear alias drops every written enable bit.
    assert_clear_alias_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IEN_CLR)
        |=> ((state_q.irq_en & $past(bus_wdata)) == '0));
endmodule

// File: rtl/gpb_mask_or.sv
module gpb_mask_or
    import gpb_pkg::*;
(
    input  pvec_t flags_i,
    input  pvec_t mask_i,
    output logic  any_o
);
    assign any_o = |(flags_i & mask_i);
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
    import gpb_pkg::*;
#(
    parameter logic [31:0] REV_ID = 32'h0000_0018
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [31:0]   pin_i,
    output logic [31:0]   pin_o,
    output logic [31:0]   pin_dir_in,
    output logic          irq_o,
    output logic          wake_o
);
    regs_t regs;
    pvec_t level, evt;

    gpb_sample_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .det_lo   (regs.det_lo),
        .det_hi   (regs.det_hi),
        .det_rise (regs.det_rise),
        .det_fall (regs.det_fall),
        .level_o  (level),
        .evt_o    (evt)
    );

    gpb_regs #(.REV_ID(REV_ID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level_i   (level),
        .evt_i     (evt),
        .regs_o    (regs)
    );

    gpb_mask_or u_irq_or (
        .flags_i (regs.status),
        .mask_i  (regs.irq_en),
        .any_o   (irq_o)
    );

    gpb_mask_or u_wake_or (
        .flags_i (regs.status),
        .mask_i  (regs.wake_en),
        .any_o   (wake_o)
    );

    assign pin_o      = regs.dout;
    assign pin_dir_in = regs.dir_in;
endmodule

// File: tb/tb_pin_bank_irq.sv
module tb_pin_bank_irq;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REV = 32'h0000_0018;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pin_i, pin_o, pin_dir_in;
    logic        irq_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pin_bank_irq #(.REV_ID(REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_dir_in(pin_dir_in), .irq_o(irq_o), .wake_o(wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic string tag_of(input int c);
        case (c)
            1: return "R5";
            2: return "R6";
            4: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, lo, hi, ri, fa, a_v, b_v, exp_v, pat, dv;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(8'h34, rd); chk("R1 dir reg", rd, 32'hFFFF_FFFF);
        chk("R1 pin_dir_in", pin_dir_in, 32'hFFFF_FFFF);
        chk("R1 pin_o", pin_o, 32'h0);
        bus_read(8'h18, rd); chk("R1 status", rd, 32'h0);
        bus_read(8'h1C, rd); chk("R1 irq enable", rd, 32'h0);
        bus_read(8'h84, rd); chk("R1 wake enable", rd, 32'h0);
        bus_read(8'h40, rd); chk("R1 low detect", rd, 32'h0);
        bus_read(8'h48, rd); chk("R1 rise detect", rd, 32'h0);
        chk("R1 irq/wake", {30'd0, irq_o, wake_o}, 32'h0);

        // R14: identification and plain storage
        bus_read(8'h00, rd); chk("R14 revision", rd, REV);
        bus_read(8'h14, rd); chk("R14 reset done", rd, 32'h1);
        bus_write(8'h10, 32'hCAFE_0011); bus_read(8'h10, rd); chk("R14 sysconfig", rd, 32'hCAFE_0011);
        bus_write(8'h30, 32'h0000_0003); bus_read(8'h30, rd); chk("R14 control", rd, 32'h0000_0003);

        // R2: direction
        bus_write(8'h34, 32'hA5A5_0F0F);
        bus_read(8'h34, rd); chk("R2 dir readback", rd, 32'hA5A5_0F0F);
        chk("R2 pin_dir_in", pin_dir_in, 32'hA5A5_0F0F);

        // R3: output value and aliases
        bus_write(8'h3C, 32'h1234_5678); chk("R3 direct", pin_o, 32'h1234_5678);
        bus_write(8'h94, 32'h0000_00F0); chk("R3 set alias", pin_o, 32'h1234_56F8);
        bus_write(8'h90, 32'h1200_0008); chk("R3 clear alias", pin_o, 32'h0034_56F0);
        bus_read(8'h94, rd); chk("R3 readback", rd, 32'h0034_56F0);

        // R4: two-flop synchroniser latency
        @(negedge clk);
        pin_i = 32'h5A5A_C3C3;
        bus_read(8'h38, rd); chk("R4 no change yet", rd, 32'h0);
        @(negedge clk); bus_read(8'h38, rd); chk("R4 after one edge", rd, 32'h0);
        @(negedge clk); bus_read(8'h38, rd); chk("R4 after two edges", rd, 32'h5A5A_C3C3);

        // R5-R9 and R7/R10 sweep: every enable combination against every pin transition
        for (int r = 0; r < 2; r++) begin
            lo = '0; hi = '0; ri = '0; fa = '0; a_v = '0; b_v = '0;
            for (int k = 0; k < 32; k++) begin
                int c, p;
                c = k % 16;
                p = (k >> 4) + 2 * r;
                lo[k] = c[0]; hi[k] = c[1]; ri[k] = c[2]; fa[k] = c[3];
                a_v[k] = p[1]; b_v[k] = p[0];
            end
            bus_write(8'h40, '0); bus_write(8'h44, '0);
            bus_write(8'h48, '0); bus_write(8'h4C, '0);
            @(negedge clk); pin_i = a_v;
            repeat (4) @(negedge clk);
            bus_write(8'h18, 32'hFFFF_FFFF);
            bus_write(8'h40, lo); bus_write(8'h44, hi);
            bus_write(8'h48, ri); bus_write(8'h4C, fa);
            pin_i = b_v;
            repeat (4) @(negedge clk);
            exp_v = (lo & (~a_v | ~b_v)) | (hi & (a_v | b_v)) | (ri & ~a_v & b_v) | (fa & a_v & ~b_v);
            bus_read(8'h18, rd);
            for (int k = 0; k < 32; k++)
                chk($sformatf("%s sweep round %0d pin %0d", tag_of(k % 16), r, k), {31'd0, rd[k]}, {31'd0, exp_v[k]});
            // R10 and R7: after a full clear only held levels come back
            bus_write(8'h18, 32'hFFFF_FFFF);
            repeat (2) @(negedge clk);
            exp_v = (lo & ~b_v) | (hi & b_v);
            bus_read(8'h18, rd);
            chk($sformatf("R10 re-set after clear round %0d", r), rd, exp_v);
        end

        // R11: detection and clear in the same cycle
        bus_write(8'h40, '0); bus_write(8'h44, '0); bus_write(8'h4C, '0);
        bus_write(8'h48, 32'h0000_0006);
        @(negedge clk); pin_i = '0;
        repeat (4) @(negedge clk);
        bus_write(8'h18, 32'hFFFF_FFFF);
        pin_i = 32'h0000_0006;
        repeat (4) @(negedge clk);
        pin_i = '0;
        repeat (4) @(negedge clk);
        bus_read(8'h18, rd); chk("R7 rise set bits", rd, 32'h0000_0006);
        pin_i = 32'h0000_0002;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0000_0006;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(8'h18, rd); chk("R11 detect beats clear", rd, 32'h0000_0002);

        // R10: partial clear leaves unwritten bits
        bus_write(8'h48, '0);
        bus_write(8'h18, 32'h0000_0004);
        bus_read(8'h18, rd); chk("R10 zero bits kept", rd, 32'h0000_0002);

        // Build a held status pattern with high-level detect
        pat = 32'h9C3A_5E61;
        bus_write(8'h44, 32'hFFFF_FFFF);
        pin_i = pat;
        repeat (4) @(negedge clk);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h18, rd); chk("R10 held level survives clear", rd, pat);

        // R12: interrupt output per pin
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h1C, 32'h1 << i);
            chk($sformatf("R12 irq pin %0d", i), {31'd0, irq_o}, {31'd0, pat[i]});
        end
        bus_write(8'h1C, '0);
        chk("R12 irq off", {31'd0, irq_o}, 32'h0);
        bus_write(8'h64, 32'h0000_0F00);
        bus_write(8'h64, 32'h0001_0000);
        bus_write(8'h60, 32'h0000_0300);
        bus_read(8'h1C, rd); chk("R12 alias result", rd, 32'h0001_0C00);
        dv = pat & 32'h0001_0C00;
        chk("R12 irq via aliases", {31'd0, irq_o}, {31'd0, |dv});
        bus_write(8'h60, 32'hFFFF_FFFF);

        // R13: wake output per pin
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h84, 32'h1 << i);
            chk($sformatf("R13 wake pin %0d", i), {31'd0, wake_o}, {31'd0, pat[i]});
            bus_write(8'h80, 32'h1 << i);
        end
        bus_read(8'h80, rd); chk("R13 wake enable cleared", rd, 32'h0);
        chk("R13 wake off", {31'd0, wake_o}, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule